// File: doc/BRIEF.md
# Grouped servo PWM generator

This block drives a bank of servo-style pulse outputs. The outputs are split into groups. Each group owns one up-counting timer, and that timer paces two neighbouring channels. Channel numbers run through the groups in order: group k owns channels 2k and 2k+1. The timers advance on a common tick. A fixed base divider and a per-timer divider derive that tick from the block clock; with the default divisors (2 and 80) a 160 MHz clock gives a 1 MHz tick.

A single-cycle write port controls the block. Through it, software sets the period of each group in ticks and the pulse width of each channel in ticks. It can also enable or disable a channel, and it can apply a default period to every group that has not been made fast.

- A channel output rises when its timer passes zero and falls when the timer equals the channel's compare value.
- Widths and periods are held in shadow registers and move into the active registers only at counter zero, so a running cycle is never cut short.
- Requested periods and widths are clamped to servo-safe limits.

Top module: `servo_pwm_bank`

## Requirements
- R1: After reset every output is low, every group period is DEF_PER ticks, every compare value is 0 and every channel is enabled.
- R2: The timer ticks once every GRP_DIV*TMR_DIV clocks, and a channel's output repeats every P ticks, where P is its group's active period.
- R3: Channels 2k and 2k+1 share the period of group k; their widths are independent.
- R4: An output goes high at timer zero and goes low when the timer equals the compare value. When both happen on the same tick, low wins, so a width of 0 keeps the output low.
- R5: A compare value greater than or equal to the group period never matches, and the output stays high through the whole cycle.
- R6: A written width or period takes effect only at the next timer zero; the pulse and cycle in progress keep their old lengths.
- R7: Writing enable=0 lets the pulse in progress finish and keeps the output low from the next cycle on. Writing enable=1 restores pulses.
- R8: A written period (group or default) is clamped into [MIN_PER, MAX_PER].
- R9: A written width above MAX_W is stored as MAX_W.
- R10: A group period write whose clamped value is below DEF_PER marks that group fast, and the mark stays until reset. A default-period write (op 3) updates only groups that are not fast and never marks a group fast.
- R11: Write encoding: wr_op 0 writes the width of channel wr_idx; op 1 writes the enable of channel wr_idx from wr_data[0]; op 2 writes the period of group wr_idx; op 3 writes the default period to all groups (wr_idx ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_op | input | 2 | Write operation code (R11) |
| wr_idx | input | IDX_W | Channel or group index |
| wr_data | input | CNT_W | Width, period or enable value |
| pwm_out | output | NUM_GRP*CH_PER_GRP | Channel outputs, bit n is channel n |

## Verification
A wrong internal state shows up at the ports as a wrong pulse length, a wrong distance between rising edges, or a missing or stuck edge:

- A bad shadow or active register appears within one period of the write that should have changed it.
- A wrong fast mark appears only when a later default-period write moves a group it should have spared, or spares a group it should have moved.
- Enable and transfer-at-zero faults appear in the cycle that is running when the write lands. They show as a truncated or stretched pulse or cycle, or as an edge after a disable.

For these reasons the bench times whole pulses and whole cycles across each write.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  typedef enum logic [1:0] {
    OP_WIDTH   = 2'd0,
    OP_ENABLE  = 2'd1,
    OP_PERIOD  = 2'd2,
    OP_DEFAULT = 2'd3
  } wr_op_e;
endpackage

// File: rtl/spwm_divider.sv
module spwm_divider #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_en,
  output logic out_en
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_count
      logic [CW-1:0] cnt_q, cnt_d;
      logic          last;

      assign last   = (cnt_q == CW'(DIV - 1));
      assign out_en = in_en && last;

      always_comb begin
        cnt_d = cnt_q;
        if (in_en) cnt_d = last ? '0 : cnt_q + CW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      // R2
      div_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |=> !out_en);
    end else begin : g_pass
      assign out_en = in_en;
    end
  endgenerate
endmodule

// File: rtl/spwm_timer.sv
module spwm_timer #(
  parameter int CNT_W   = 16,
  parameter int MIN_PER = 2500,
  parameter int MAX_PER = 62500,
  parameter int DEF_PER = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             set_we,
  input  logic             dflt_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_PER);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_PER);
  localparam logic [CNT_W-1:0] DEF_V = CNT_W'(DEF_PER);

  logic [CNT_W-1:0] cnt_q, cnt_d, shd_q, shd_d, act_q, act_d, clamped;
  logic             fast_q, fast_d, at_zero;

  assign at_zero = (cnt_q == '0);
  assign clamped = (wdata < MIN_V) ? MIN_V : ((wdata > MAX_V) ? MAX_V : wdata);

  always_comb begin
    shd_d  = shd_q;
    fast_d = fast_q;
    if (set_we) begin
      shd_d = clamped;
      if (clamped < DEF_V) fast_d = 1'b1;
    end else if (dflt_we && !fast_q) begin
      shd_d = clamped;
    end
    cnt_d = cnt_q;
    act_d = act_q;
    if (tick) begin
      cnt_d = (cnt_q == act_q - CNT_W'(1)) ? '0 : cnt_q + CNT_W'(1);
      if (at_zero) act_d = shd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      shd_q  <= DEF_V;
      act_q  <= DEF_V;
      fast_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      shd_q  <= shd_d;
      act_q  <= act_d;
      fast_q <= fast_d;
    end
  end

  assign cnt = cnt_q;

  // R8
  period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_q >= MIN_V) && (shd_q <= MAX_V));
  // R6
  period_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(tick && at_zero));
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < act_q);
  // R10
  fast_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_q |=> fast_q);
endmodule

// File: rtl/spwm_channel.sv
module spwm_channel #(
  parameter int CNT_W = 16,
  parameter int MAX_W = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             width_we,
  input  logic             en_we,
  input  logic [CNT_W-1:0] wdata,
  output logic             pwm
);
  localparam logic [CNT_W-1:0] MAXW_V = CNT_W'(MAX_W);

  logic [CNT_W-1:0] shd_q, shd_d, cmp_q, cmp_d, cmp_eff;
  logic             en_q, en_d, out_q, out_d, at_zero;

  assign at_zero = (cnt == '0);
  assign cmp_eff = at_zero ? shd_q : cmp_q;

  always_comb begin
    shd_d = width_we ? ((wdata > MAXW_V) ? MAXW_V : wdata) : shd_q;
    en_d  = en_we ? wdata[0] : en_q;
    cmp_d = cmp_q;
    out_d = out_q;
    if (tick) begin
      if (at_zero) cmp_d = shd_q;
      if (cnt == cmp_eff) out_d = 1'b0;
      else if (at_zero)   out_d = en_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      cmp_q <= '0;
      en_q  <= 1'b1;
      out_q <= 1'b0;
    end else begin
      shd_q <= shd_d;
      cmp_q <= cmp_d;
      en_q  <= en_d;
      out_q <= out_d;
    end
  end

  assign pwm = out_q;

  // R4
  rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(tick && at_zero));
  // R9
  width_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shd_q <= MAXW_V);
  // R7
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_zero && !en_q) |=> !out_q);
  // R4
  zero_width_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_zero && shd_q == '0) |=> !out_q);
endmodule

// File: rtl/servo_pwm_bank.sv
module servo_pwm_bank #(
  parameter int NUM_GRP    = 6,
  parameter int CH_PER_GRP = 2,
  parameter int CNT_W      = 16,
  parameter int GRP_DIV    = 2,
  parameter int TMR_DIV    = 80,
  parameter int MIN_PER    = 2500,
  parameter int MAX_PER    = 62500,
  parameter int DEF_PER    = 20000,
  parameter int MAX_W      = 20000,
  localparam int NUM_CH    = NUM_GRP * CH_PER_GRP,
  localparam int IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_op,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NUM_CH-1:0] pwm_out
);
  import spwm_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       base_en;
  logic       dflt_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign dflt_we = wr_en && (wr_op == OP_DEFAULT);

  spwm_divider #(.DIV(GRP_DIV)) u_base_div (
    .clk(clk), .rst_n(rst_int_n), .in_en(1'b1), .out_en(base_en)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             per_we;

    assign per_we = wr_en && (wr_op == OP_PERIOD) && (wr_idx == IDX_W'(g));

    spwm_divider #(.DIV(TMR_DIV)) u_tmr_div (
      .clk(clk), .rst_n(rst_int_n), .in_en(base_en), .out_en(tick)
    );

    spwm_timer #(
      .CNT_W(CNT_W), .MIN_PER(MIN_PER), .MAX_PER(MAX_PER), .DEF_PER(DEF_PER)
    ) u_timer (
      .clk(clk), .rst_n(rst_int_n), .tick(tick), .set_we(per_we),
      .dflt_we(dflt_we), .wdata(wr_data), .cnt(cnt)
    );

    for (genvar c = 0; c < CH_PER_GRP; c++) begin : g_ch
      localparam int CH = g * CH_PER_GRP + c;
      logic w_we, e_we;

      assign w_we = wr_en && (wr_op == OP_WIDTH)  && (wr_idx == IDX_W'(CH));
      assign e_we = wr_en && (wr_op == OP_ENABLE) && (wr_idx == IDX_W'(CH));

      spwm_channel #(.CNT_W(CNT_W), .MAX_W(MAX_W)) u_ch (
        .clk(clk), .rst_n(rst_int_n), .tick(tick), .cnt(cnt),
        .width_we(w_we), .en_we(e_we), .wdata(wr_data), .pwm(pwm_out[CH])
      );
    end
  end

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_int_n |=> (pwm_out == '0));
endmodule

// File: tb/servo_pwm_bank_test.sv
module servo_pwm_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 6;
  localparam int NC = 12;
  localparam int GDIV = 2;
  localparam int TDIV = 2;
  localparam int TCK = GDIV * TDIV;
  localparam int MINP = 40;
  localparam int MAXP = 500;
  localparam int DEFP = 200;
  localparam int MAXW = 200;
  localparam int LIM = MAXP * TCK + 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_op = 2'd0;
  logic [3:0] wr_idx = 4'd0;
  logic [15:0] wr_data = 16'd0;
  logic [NC-1:0] pwm_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  servo_pwm_bank #(
    .NUM_GRP(NG), .CH_PER_GRP(2), .CNT_W(16), .GRP_DIV(GDIV), .TMR_DIV(TDIV),
    .MIN_PER(MINP), .MAX_PER(MAXP), .DEF_PER(DEFP), .MAX_W(MAXW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op),
    .wr_idx(wr_idx), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int clamp_per(int p);
    return (p < MINP) ? MINP : ((p > MAXP) ? MAXP : p);
  endfunction

  function automatic int clamp_w(int w);
    return (w > MAXW) ? MAXW : w;
  endfunction

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(int op, int idx, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_op = 2'(op); wr_idx = 4'(idx); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (2 * MAXP * TCK + 10) @(negedge clk);
  endtask

  task automatic wait_rise(int ch, output bit ok);
    bit prev;
    ok = 1'b0;
    prev = pwm_out[ch];
    for (int i = 0; i < LIM; i++) begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) begin ok = 1'b1; break; end
      prev = pwm_out[ch];
    end
  endtask

  task automatic count_high(int ch, output int n);
    n = 0;
    for (int i = 0; i < LIM; i++) begin
      @(negedge clk);
      if (!pwm_out[ch]) break;
      n++;
    end
  endtask

  task automatic count_to_rise(int ch, output int n);
    bit prev;
    n = 0;
    prev = pwm_out[ch];
    for (int i = 0; i < LIM; i++) begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) break;
      prev = pwm_out[ch];
      n++;
    end
  endtask

  // hi/per in clocks, -1 when no rising edge shows up
  task automatic measure(int ch, output int hi, output int per);
    bit ok;
    int n;
    wait_rise(ch, ok);
    if (!ok) begin hi = -1; per = -1; return; end
    count_high(ch, n);
    hi = n + 1;
    count_to_rise(ch, n);
    per = hi + 1 + n;
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int hi, per, n, lvl;
    bit ok;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: outputs low after reset, compare 0
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pwm_out != '0) n++;
    end
    check("R1 outputs low after reset", n, 0);

    // R2 R3 R4: group 0 at default period, two widths
    wr(0, 0, 50);
    wr(0, 1, 120);
    settle();
    measure(0, hi, per);
    check("R4 ch0 high time", hi, 50 * TCK);
    check("R2 ch0 default period", per, DEFP * TCK);
    measure(1, hi, per);
    check("R3 ch1 own width", hi, 120 * TCK);
    check("R3 ch1 shared period", per, DEFP * TCK);

    // R4: width 0 keeps output low (low beats high)
    wr(0, 2, 30);
    settle();
    wr(0, 2, 0);
    settle();
    measure(2, hi, per);
    check("R4 width zero no edge", hi, -1);
    check("R4 width zero level", int'(pwm_out[2]), 0);

    // R9: width clamp, R2: slower group period
    wr(2, 1, 400);
    wr(0, 3, 300);
    settle();
    measure(3, hi, per);
    check("R9 width clamped", hi, clamp_w(300) * TCK);
    check("R2 group1 period", per, 400 * TCK);

    // R8: period clamps low and high
    wr(2, 2, 10);
    wr(0, 4, 20);
    wr(2, 3, 1000);
    wr(0, 6, 30);
    settle();
    measure(4, hi, per);
    check("R8 period clamp low", per, clamp_per(10) * TCK);
    measure(6, hi, per);
    check("R8 period clamp high", per, clamp_per(1000) * TCK);

    // R5: compare >= period keeps output high
    wr(2, 4, 100);
    wr(0, 8, 150);
    wr(0, 9, 100);
    settle();
    measure(8, hi, per);
    check("R5 compare above period no edge", hi, -1);
    check("R5 compare above period level", int'(pwm_out[8]), 1);
    lvl = 1;
    for (int i = 0; i < 100 * TCK; i++) begin
      @(negedge clk);
      if (!pwm_out[9]) lvl = 0;
    end
    check("R5 compare equal period stays high", lvl, 1);

    // R10: default period spares fast groups (2 and 4)
    wr(3, 0, 300);
    settle();
    measure(0, hi, per);
    check("R10 non-fast group takes default", per, 300 * TCK);
    measure(3, hi, per);
    check("R10 group1 (slow) takes default", per, 300 * TCK);
    measure(4, hi, per);
    check("R10 fast group2 kept", per, MINP * TCK);
    wr(3, 0, 100);
    settle();
    wr(3, 0, 300);
    settle();
    measure(0, hi, per);
    check("R10 default write does not mark fast", per, 300 * TCK);

    // R6: period change mid-cycle does not cut the running cycle
    wait_rise(0, ok);
    repeat (20) @(negedge clk);
    wr(2, 0, 250);
    count_to_rise(0, n);
    check("R6 running cycle keeps old period", 1 + 20 + 2 + n, 300 * TCK);
    measure(0, hi, per);
    check("R6 new period after zero", per, 250 * TCK);

    // R6: width change mid-pulse
    wait_rise(1, ok);
    repeat (10) @(negedge clk);
    wr(0, 1, 40);
    count_high(1, n);
    check("R6 running pulse keeps old width", 1 + 10 + 2 + n, 120 * TCK);
    measure(1, hi, per);
    check("R6 new width after zero", hi, 40 * TCK);

    // R7: disable mid-pulse completes pulse then stays low
    wait_rise(1, ok);
    repeat (10) @(negedge clk);
    wr(1, 1, 0);
    count_high(1, n);
    check("R7 pulse completes after disable", 1 + 10 + 2 + n, 40 * TCK);
    measure(1, hi, per);
    check("R7 no edge while disabled", hi, -1);
    check("R7 level low while disabled", int'(pwm_out[1]), 0);
    measure(0, hi, per);
    check("R7 sibling unaffected", hi, 50 * TCK);
    wr(1, 1, 1);
    settle();
    measure(1, hi, per);
    check("R7 enable restores pulses", hi, 40 * TCK);

    // R2 R3 R11: random group periods and widths
    for (int it = 0; it < 6; it++) begin
      int g, p, w0, w1, wl;
      g  = $urandom_range(NG - 1, 0);
      p  = $urandom_range(MAXP, MINP);
      wl = (p - 1 < MAXW) ? p - 1 : MAXW;
      w0 = $urandom_range(wl, 1);
      w1 = $urandom_range(wl, 1);
      wr(2, g, p);
      wr(0, 2 * g, w0);
      wr(0, 2 * g + 1, w1);
      settle();
      measure(2 * g, hi, per);
      check("R11 random even channel width", hi, w0 * TCK);
      check("R2 random period", per, p * TCK);
      measure(2 * g + 1, hi, per);
      check("R3 random odd channel width", hi, w1 * TCK);
      check("R3 random odd channel period", per, p * TCK);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule